// File: doc/BRIEF.md
# Isochronous IN Zero-Length Responder

This block decides how an isochronous IN endpoint answers each IN token. It sits between the token decoder and the packet transmitter. The endpoint may carry one to three packets per microframe. When a packet is buffered, the block orders the transmitter to send it. When nothing is buffered, it orders a zero-length packet instead of leaving the host to hit a turnaround timeout. In both cases it supplies the data PID that the packet's position in the microframe calls for, so the host sees an unbroken PID sequence even when the source falls behind.

A packet index counts answered tokens inside the current microframe. The microframe start strobe resets it. Once the configured count has been answered, further tokens are dropped until the next microframe. An auto-adjust mode bit, low by default, changes one behaviour: when the buffer is empty, the zero-length packet is tagged DATA0 and the microframe is closed early. With the bit low, the fixed position-based sequence is kept. A system that sets the auto-adjust bit must keep its maximum packet size at 1024 bytes or less; this block does not enforce that limit.

Every pin is a plain control strobe or level. The command is a single-cycle pulse that the transmitter must accept in that cycle; there is no back-pressure, because an IN token must be answered within the bus turnaround time.

Top module: `iso_zlp_responder`

## Requirements
- R1: While reset is active, and in the first cycle after it, no command is issued, and the packet index returns to zero. The first token after reset is therefore answered as the first packet of a microframe, even without a microframe start.
- R2: An IN token accepted while the packet-ready flag is high yields a one-cycle `send_data_o` pulse in the cycle after the token. A cycle with no token yields no command.
- R3: With auto-adjust low, an IN token accepted while the packet-ready flag is low yields a one-cycle `send_zlp_o` pulse in the cycle after the token.
- R4: With N packets per microframe, the answer at index k (counting from 0) carries PID code N-1-k. The codes are DATA0 = 2'b00, DATA1 = 2'b01 and DATA2 = 2'b10, so for N=3 the sequence is DATA2, DATA1, DATA0.
- R5: A zero-length packet sent with auto-adjust low carries the same PID that a data packet at that index would carry.
- R6: The microframe start strobe resets the index to zero. A token in the same cycle as the strobe is answered as index 0 of the new microframe.
- R7: After N tokens have been answered in a microframe, further tokens produce no command until the next microframe start.
- R8: A configured count of 0 is treated as 1.
- R9: With auto-adjust high, a token that finds the buffer empty is answered with a zero-length packet tagged DATA0. The remaining tokens of that microframe are then ignored.
- R10: `send_data_o` and `send_zlp_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_start_i | input | 1 | Microframe start strobe |
| in_tok_i | input | 1 | IN token strobe for this endpoint |
| pkt_rdy_i | input | 1 | A full data packet is buffered |
| ppm_cfg_i | input | PPM_W (2) | Configured packets per microframe, 1 to MAX_PPM |
| auto_adj_i | input | 1 | Auto-adjust mode bit, 0 keeps the fixed sequence |
| send_data_o | output | 1 | Pulse: transmit the buffered packet |
| send_zlp_o | output | 1 | Pulse: transmit a zero-length packet |
| pid_o | output | 2 | Data PID for the commanded packet |

## Verification
The bench builds the block with its default parameters, PPM_W = 2 and MAX_PPM = 3. These values reach every PID code, every configured count from 0 to 3, and the full DATA2-to-DATA0 sequence. A table of per-cycle vectors switches the count, the ready flag and the auto-adjust bit at microframe boundaries. This exercises mid-sequence zero-length packets, token drops after the last slot, a token that coincides with a microframe start, and early closing in auto-adjust mode. Directed cases then cover reset entry in mid-microframe and check that the index restarts from zero afterwards.

// File: rtl/iso_zlp_pkg.sv
package iso_zlp_pkg;

  // Data PID codes handed to the packet transmitter
  typedef enum logic [1:0] {
    PID_D0 = 2'b00,
    PID_D1 = 2'b01,
    PID_D2 = 2'b10
  } dpid_e;

endpackage

// File: rtl/iso_zlp_ppm_norm.sv
// Turns the configured count into an effective count of 1..MAX_PPM.
module iso_zlp_ppm_norm #(
  parameter int PPM_W   = 2,
  parameter int MAX_PPM = 3,
  localparam int IDX_W  = $clog2(MAX_PPM + 1)
) (
  input  logic [PPM_W-1:0] ppm_cfg_i,
  output logic [IDX_W-1:0] n_eff_o
);

  always_comb begin
    if (ppm_cfg_i == '0)
      n_eff_o = IDX_W'(1);                 // zero means one packet (R8)
    else if (int'(ppm_cfg_i) > MAX_PPM)
      n_eff_o = IDX_W'(MAX_PPM);
    else
      n_eff_o = IDX_W'(ppm_cfg_i);
  end

endmodule

// File: rtl/iso_zlp_slot_ctr.sv
// Packet index inside the current microframe.
module iso_zlp_slot_ctr #(
  parameter int MAX_PPM = 3,
  localparam int IDX_W  = $clog2(MAX_PPM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uframe_start_i,
  input  logic             advance_i,
  input  logic             close_i,
  input  logic [IDX_W-1:0] close_val_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  // a microframe start takes effect in the cycle it arrives
  assign idx_o = uframe_start_i ? '0 : idx_q;

  always_comb begin
    if (close_i)
      idx_d = close_val_i;
    else if (advance_i)
      idx_d = idx_o + IDX_W'(1);
    else
      idx_d = idx_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx_q <= '0;
    else
      idx_q <= idx_d;
  end

  // R6: a start strobe with nothing answered leaves the index at zero
  p_idx_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uframe_start_i && !advance_i && !close_i) |=> (idx_q == '0));

  // R7: the index never runs past the largest count
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) <= MAX_PPM);

endmodule

// File: rtl/iso_zlp_pid_sel.sv
// Picks the data PID for the packet at the current index.
module iso_zlp_pid_sel
  import iso_zlp_pkg::*;
#(
  parameter int MAX_PPM = 3,
  localparam int IDX_W  = $clog2(MAX_PPM + 1)
) (
  input  logic [IDX_W-1:0] n_eff_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             force_d0_i,
  output dpid_e            pid_o
);

  logic [IDX_W-1:0] remaining;

  // packets still to come after this one
  assign remaining = n_eff_i - idx_i - IDX_W'(1);

  always_comb begin
    if (force_d0_i)
      pid_o = PID_D0;
    else
      pid_o = dpid_e'(2'(remaining));
  end

endmodule

// File: rtl/iso_zlp_responder.sv
module iso_zlp_responder
  import iso_zlp_pkg::*;
#(
  parameter int PPM_W   = 2,
  parameter int MAX_PPM = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uframe_start_i,
  input  logic             in_tok_i,
  input  logic             pkt_rdy_i,
  input  logic [PPM_W-1:0] ppm_cfg_i,
  input  logic             auto_adj_i,
  output logic             send_data_o,
  output logic             send_zlp_o,
  output logic [1:0]       pid_o
);

  localparam int IDX_W = $clog2(MAX_PPM + 1);

  logic [IDX_W-1:0] n_eff;
  logic [IDX_W-1:0] idx;
  logic             accept;
  logic             early_close;
  dpid_e            pid_sel;

  iso_zlp_ppm_norm #(.PPM_W(PPM_W), .MAX_PPM(MAX_PPM)) u_norm (
    .ppm_cfg_i (ppm_cfg_i),
    .n_eff_o   (n_eff)
  );

  iso_zlp_slot_ctr #(.MAX_PPM(MAX_PPM)) u_slot (
    .clk            (clk),
    .rst_n          (rst_n),
    .uframe_start_i (uframe_start_i),
    .advance_i      (accept),
    .close_i        (early_close),
    .close_val_i    (n_eff),
    .idx_o          (idx)
  );

  // a token is answered only while slots remain in this microframe
  assign accept      = in_tok_i && (idx < n_eff);
  assign early_close = accept && auto_adj_i && !pkt_rdy_i;

  iso_zlp_pid_sel #(.MAX_PPM(MAX_PPM)) u_pid (
    .n_eff_i    (n_eff),
    .idx_i      (idx),
    .force_d0_i (early_close),
    .pid_o      (pid_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_data_o <= 1'b0;
      send_zlp_o  <= 1'b0;
      pid_o       <= PID_D0;
    end else begin
      send_data_o <= accept && pkt_rdy_i;
      send_zlp_o  <= accept && !pkt_rdy_i;
      if (accept)
        pid_o <= pid_sel;
    end
  end

  // R10: at most one command per cycle
  p_single_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_data_o && send_zlp_o));

  // R2: a data command follows a cycle with a packet buffered
  p_data_has_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_data_o |-> $past(pkt_rdy_i));

  // R3: a zero-length command follows a cycle with an empty buffer
  p_zlp_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_zlp_o |-> !$past(pkt_rdy_i));

  // R7: no command without a token the cycle before
  p_cmd_needs_tok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (send_data_o || send_zlp_o) |-> $past(in_tok_i));

  // R6: a token on a microframe start with a packet buffered is always served
  p_start_tok_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uframe_start_i && in_tok_i && pkt_rdy_i) |=> send_data_o);

  // R9: in auto-adjust mode a zero-length answer carries DATA0
  p_auto_zlp_d0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (send_zlp_o && $past(auto_adj_i)) |-> (pid_o == PID_D0));

endmodule

// File: tb/tb_iso_zlp_responder.sv
module tb_iso_zlp_responder;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       uframe_start_i, in_tok_i, pkt_rdy_i, auto_adj_i;
  logic [1:0] ppm_cfg_i;
  logic       send_data_o, send_zlp_o;
  logic [1:0] pid_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_zlp_responder dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .uframe_start_i (uframe_start_i),
    .in_tok_i       (in_tok_i),
    .pkt_rdy_i      (pkt_rdy_i),
    .ppm_cfg_i      (ppm_cfg_i),
    .auto_adj_i     (auto_adj_i),
    .send_data_o    (send_data_o),
    .send_zlp_o     (send_zlp_o),
    .pid_o          (pid_o)
  );

  // {start, tok, rdy, auto, ppm[1:0], exp_data, exp_zlp, exp_pid[1:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0_0_0_11_0_0_00, // start, N=3
    10'b0_1_1_0_11_1_0_10, // R2 R4: DATA2
    10'b0_1_0_0_11_0_1_01, // R3 R5: ZLP DATA1
    10'b0_1_1_0_11_1_0_00, // R4: DATA0
    10'b0_1_1_0_11_0_0_00, // R7: dropped
    10'b1_1_1_0_11_1_0_10, // R6: token on start
    10'b0_0_1_0_11_0_0_00, // R2: idle
    10'b1_0_0_0_10_0_0_00, // start, N=2
    10'b0_1_1_0_10_1_0_01, // R4: DATA1
    10'b0_1_0_0_10_0_1_00, // R5: ZLP DATA0
    10'b0_1_1_0_10_0_0_00, // R7: dropped
    10'b1_1_0_0_01_0_1_00, // R5: N=1 ZLP DATA0
    10'b0_1_1_0_01_0_0_00, // R7: dropped
    10'b1_1_1_0_00_1_0_00, // R8: N=0 as 1
    10'b0_1_1_0_00_0_0_00, // R8: second dropped
    10'b1_1_1_1_11_1_0_10, // R9: auto, data DATA2
    10'b0_1_0_1_11_0_1_00, // R9: empty -> ZLP DATA0
    10'b0_1_1_1_11_0_0_00, // R9: closed
    10'b1_1_0_1_11_0_1_00, // R9: first empty -> DATA0
    10'b0_1_1_1_11_0_0_00  // R9: closed
  };

  task automatic check_out(input string tag, input logic ed, input logic ez,
                           input logic [1:0] ep);
    logic ok;
    ok = (send_data_o === ed) && (send_zlp_o === ez) &&
         (!(ed || ez) || (pid_o === ep));
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got data=%b zlp=%b pid=%b, expected data=%b zlp=%b pid=%b",
               tag, send_data_o, send_zlp_o, pid_o, ed, ez, ep);
    end
  endtask

  task automatic drive(input logic s, input logic t, input logic r,
                       input logic a, input logic [1:0] p);
    @(negedge clk);
    uframe_start_i = s; in_tok_i = t; pkt_rdy_i = r; auto_adj_i = a; ppm_cfg_i = p;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    uframe_start_i = 0; in_tok_i = 0; pkt_rdy_i = 0; auto_adj_i = 0; ppm_cfg_i = 2'd3;
    // R1: tokens during reset produce nothing
    drive(0, 1, 1, 0, 2'd3);
    check_out("R1 reset quiet", 0, 0, 2'b00);
    drive(0, 1, 0, 0, 2'd3);
    check_out("R1 reset quiet zlp", 0, 0, 2'b00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:4]);
      check_out($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8 R9 R10)", i),
                VEC[i][3], VEC[i][2], VEC[i][1:0]);
    end

    // R1: reset in mid-microframe, index restarts without a start strobe
    drive(1, 1, 1, 0, 2'd3);
    check_out("R1 pre-reset DATA2", 1, 0, 2'b10);
    @(negedge clk); rst_n = 1'b0;
    uframe_start_i = 0; in_tok_i = 0;
    @(posedge clk); #1;
    check_out("R1 outputs cleared", 0, 0, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    drive(0, 1, 1, 0, 2'd3);
    check_out("R1 index restarted DATA2", 1, 0, 2'b10);
    drive(0, 0, 0, 0, 2'd3);
    check_out("R2 pulse is one cycle", 0, 0, 2'b00);
    drive(0, 1, 0, 0, 2'd3);
    check_out("R5 ZLP mid sequence DATA1", 0, 1, 2'b01);

    // R7: drops persist across idle cycles until a start
    drive(0, 1, 1, 0, 2'd3);
    check_out("R4 third DATA0", 1, 0, 2'b00);
    drive(0, 0, 1, 0, 2'd3);
    drive(0, 1, 1, 0, 2'd3);
    check_out("R7 still dropped", 0, 0, 2'b00);
    drive(1, 0, 1, 0, 2'd2);
    drive(0, 1, 1, 0, 2'd2);
    check_out("R6 start re-opens DATA1", 1, 0, 2'b01);

    drive(0, 0, 0, 0, 2'd3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule